// File: doc/BRIEF.md
# I2C Start and Repeated-Start Trigger

This block decides when an I2C master may begin a transfer and produces the start waveform on the bus lines. Software asks for a start with a one-cycle write strobe, and the block checks that strobe against the master's current phase. A start is refused if it arrives in the same write as a stop, during a byte transfer, or during the acknowledge slot. A refused request leaves no trace.

A request made while the bus is free produces a start at once. A request made while the master is stalled after the ninth clock produces a repeated start when that wait is released. If another master owns the bus, the request is either held in reserve until the bus frees, or it is refused and a failure flag is raised, depending on a reservation-disable input. The start hold time is a parameter counted in system clocks. Once SCL has been pulled low, a one-cycle completion strobe is raised and the lines stay low until the master engine takes over.

Top module: `i2c_start_ctl`

## Requirements
- R1: A start drives SDA low while SCL stays high. SCL goes low exactly HOLD_CYC clocks after SDA falls. `start_done_o` is high for the single cycle in which SCL is first low.
- R2: A request accepted in the wait phase (phase 3) stays pending until `wait_release_i`. After the release, both lines are held high for HOLD_CYC clocks, and then the start of R1 follows.
- R3: With reservation enabled (`resv_dis_i`=0), a request made while `bus_busy_i`=1 stays pending with `start_bit_o`=1. SDA falls one clock after `bus_busy_i` goes low.
- R4: With reservation disabled (`resv_dis_i`=1), a request made while the bus is busy sets `resv_fail_o`, leaves `start_bit_o` at 0 and generates no start, even after the bus frees. The flag clears on the next accepted request, on release, or on disable.
- R5: A pending or running start is cancelled, and `start_bit_o` cleared, by `arb_lost_i`, by `release_i`, or by `en_i` going low. Both lines then return high.
- R6: A start request given in the same cycle as `stop_req_i` is ignored.
- R7: In transmit mode (`rx_mode_i`=0), a request is accepted only in phase 0 (idle) or phase 3 (wait after the ninth clock). It is rejected in phase 1 (byte transfer) and phase 2 (acknowledge).
- R8: In receive mode, a request in phase 3 is accepted only when `ack_en_i`=0 and `last_rx_i`=1. Phase 0 is accepted, and phases 1 and 2 are rejected.
- R9: `start_bit_o` is 1 while a request waits for the bus or for the wait release. It reads 0 from the cycle in which SDA falls.
- R10: While `en_i` is low, `sda_o` and `scl_o` are high and `start_bit_o`, `resv_fail_o` and `start_done_o` are 0 in the same cycle, and requests are ignored.
- R11: A further request while one is pending or being generated is ignored. It does not restart the hold timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Interface enable |
| start_req_i | input | 1 | Start request write strobe |
| stop_req_i | input | 1 | Stop request written in the same cycle |
| release_i | input | 1 | Exit-from-communication command |
| resv_dis_i | input | 1 | 1 = refuse requests while the bus is busy |
| bus_busy_i | input | 1 | Another master holds the bus |
| arb_lost_i | input | 1 | Arbitration lost strobe |
| phase_i | input | 2 | 0 idle, 1 byte transfer, 2 acknowledge, 3 wait after ninth clock |
| rx_mode_i | input | 1 | 1 = master reception |
| ack_en_i | input | 1 | Acknowledge generation enabled |
| last_rx_i | input | 1 | Final byte has been received |
| wait_release_i | input | 1 | Master wait state released |
| sda_o | output | 1 | SDA level, 0 = pulled low |
| scl_o | output | 1 | SCL level, 0 = pulled low |
| start_bit_o | output | 1 | Read value of the start request bit |
| resv_fail_o | output | 1 | Reservation failed flag |
| start_done_o | output | 1 | One-cycle strobe when the start is complete |

## Verification
Two events can fall in the same cycle as a start request. The first is a stop request written together with it. The second is a second request, or an arbitration loss, while a start is pending or its hold timer is running. A sweep over every phase, direction, acknowledge-enable, last-byte and stop combination confirms that the request is accepted only where R6 to R8 allow it. Separate scenarios inject a repeated request in the middle of the hold time and check that SCL still falls exactly HOLD_CYC clocks after SDA falls. They also cancel a reserved request with arbitration loss, release and disable, and confirm that no start follows once the bus frees.

// File: rtl/sct_pkg.sv
`timescale 1ns/1ps
package sct_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_XFER  = 2'd1,
    PH_ACK   = 2'd2,
    PH_WAIT9 = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RESV,
    ST_RSWAIT,
    ST_RSSETUP,
    ST_GEN,
    ST_LOW
  } st_e;
endpackage

// File: rtl/sct_gate.sv
`timescale 1ns/1ps
module sct_gate
  import sct_pkg::*;
(
  input  logic       start_req_i,
  input  logic       stop_req_i,
  input  logic [1:0] phase_i,
  input  logic       rx_mode_i,
  input  logic       ack_en_i,
  input  logic       last_rx_i,
  output logic       ok_o,
  output logic       rstart_o
);
  logic phase_ok;

  always_comb begin
    unique case (phase_e'(phase_i))
      PH_IDLE:  phase_ok = 1'b1;
      PH_WAIT9: phase_ok = !rx_mode_i || (!ack_en_i && last_rx_i);
      default:  phase_ok = 1'b0;
    endcase
  end

  assign ok_o     = start_req_i && !stop_req_i && phase_ok;
  assign rstart_o = (phase_e'(phase_i) == PH_WAIT9);
endmodule

// File: rtl/sct_timer.sv
`timescale 1ns/1ps
module sct_timer #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic done_o
);
  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LAST);

  AST_TMR_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_i) |=> done_o);  // R1
endmodule

// File: rtl/i2c_start_ctl.sv
`timescale 1ns/1ps
module i2c_start_ctl
  import sct_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       start_req_i,
  input  logic       stop_req_i,
  input  logic       release_i,
  input  logic       resv_dis_i,
  input  logic       bus_busy_i,
  input  logic       arb_lost_i,
  input  logic [1:0] phase_i,
  input  logic       rx_mode_i,
  input  logic       ack_en_i,
  input  logic       last_rx_i,
  input  logic       wait_release_i,
  output logic       sda_o,
  output logic       scl_o,
  output logic       start_bit_o,
  output logic       resv_fail_o,
  output logic       start_done_o
);
  st_e  st_q, st_d;
  logic fail_q, fail_d;
  logic done_q, done_d;
  logic gate_ok, gate_rs, tmr_done;

  sct_gate u_gate (
    .start_req_i (start_req_i),
    .stop_req_i  (stop_req_i),
    .phase_i     (phase_i),
    .rx_mode_i   (rx_mode_i),
    .ack_en_i    (ack_en_i),
    .last_rx_i   (last_rx_i),
    .ok_o        (gate_ok),
    .rstart_o    (gate_rs)
  );

  sct_timer #(.HOLD_CYC(HOLD_CYC)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st_d != st_q),
    .done_o (tmr_done)
  );

  always_comb begin
    st_d   = st_q;
    fail_d = fail_q;
    done_d = 1'b0;
    if (!en_i || release_i) begin
      st_d   = ST_IDLE;
      fail_d = 1'b0;
    end else if (arb_lost_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (gate_ok) begin
          fail_d = 1'b0;
          if (gate_rs)         st_d = ST_RSWAIT;
          else if (!bus_busy_i) st_d = ST_GEN;
          else if (resv_dis_i)  fail_d = 1'b1;
          else                  st_d = ST_RESV;
        end
        ST_RESV:    if (!bus_busy_i)    st_d = ST_GEN;
        ST_RSWAIT:  if (wait_release_i) st_d = ST_RSSETUP;
        ST_RSSETUP: if (tmr_done)       st_d = ST_GEN;
        ST_GEN: if (tmr_done) begin
          st_d   = ST_LOW;
          done_d = 1'b1;
        end
        ST_LOW:     if (wait_release_i) st_d = ST_IDLE;
        default:    st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      fail_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      fail_q <= fail_d;
      done_q <= done_d;
    end
  end

  // lines released and flags masked whenever the interface is off
  assign sda_o        = !en_i || !(st_q == ST_GEN || st_q == ST_LOW);
  assign scl_o        = !en_i || (st_q != ST_LOW);
  assign start_bit_o  = en_i && (st_q == ST_RESV || st_q == ST_RSWAIT || st_q == ST_RSSETUP);
  assign resv_fail_o  = en_i && fail_q;
  assign start_done_o = en_i && done_q;

  AST_SDA_FALL_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_o) |-> scl_o);  // R1
  AST_DONE_LINES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_done_o |-> (!scl_o && !sda_o));  // R1
  AST_RESV_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && st_q == ST_RESV && bus_busy_i && !release_i && !arb_lost_i) |=> (start_bit_o || !en_i));  // R3
  AST_FAIL_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resv_fail_o |-> (sda_o && !start_bit_o));  // R4
  AST_ARB_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && arb_lost_i) |=> !start_bit_o);  // R5
  AST_STOP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && start_req_i && stop_req_i) |=> (sda_o && !start_bit_o));  // R6
  AST_XFER_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && start_req_i && phase_i == 2'd1) |=> (sda_o && !start_bit_o));  // R7
  AST_DIS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (sda_o && scl_o && !start_bit_o && !resv_fail_o && !start_done_o));  // R10
endmodule

// File: tb/sim_i2c_start_ctl.sv
`timescale 1ns/1ps
module sim_i2c_start_ctl;
  localparam int HOLD = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic en_i = 1'b1, start_req_i = 1'b0, stop_req_i = 1'b0, release_i = 1'b0;
  logic resv_dis_i = 1'b0, bus_busy_i = 1'b0, arb_lost_i = 1'b0;
  logic [1:0] phase_i = 2'd0;
  logic rx_mode_i = 1'b0, ack_en_i = 1'b0, last_rx_i = 1'b0, wait_release_i = 1'b0;
  logic sda_o, scl_o, start_bit_o, resv_fail_o, start_done_o;
  int nchk = 0, nerr = 0;

  always #10 clk_i = !clk_i;

  i2c_start_ctl #(.HOLD_CYC(HOLD)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic go_idle();
    release_i = 1'b1; cyc(); release_i = 1'b0; cyc();
  endtask

  task automatic pulse_req();
    start_req_i = 1'b1; cyc(); start_req_i = 1'b0;
  endtask

  task automatic count_scl(output int n);
    n = 0;
    while (scl_o && n < 50) begin cyc(); n++; end
  endtask

  initial begin
    #(20 * 100000);
    nerr++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int n, m;
    cyc(2); rst_ni = 1'b1; cyc();
    // R10 reset state
    chk("R10 reset sda", sda_o, 1); chk("R10 reset scl", scl_o, 1);
    chk("R10 reset start_bit", start_bit_o, 0); chk("R10 reset fail", resv_fail_o, 0);

    // R6 R7 R8 legality sweep
    for (int ph = 0; ph < 4; ph++)
      for (int c = 0; c < 16; c++) begin
        bit rx, ak, ls, sp, exp_acc;
        rx = c[0]; ak = c[1]; ls = c[2]; sp = c[3];
        exp_acc = !sp && (ph == 0 || (ph == 3 && (!rx || (!ak && ls))));
        phase_i = ph[1:0]; rx_mode_i = rx; ack_en_i = ak; last_rx_i = ls;
        stop_req_i = sp; start_req_i = 1'b1; cyc();
        start_req_i = 1'b0; stop_req_i = 1'b0;
        chk(sp ? "R6" : (rx ? "R8" : "R7"), int'(!sda_o || start_bit_o), int'(exp_acc));
        go_idle();
      end
    phase_i = 2'd0; rx_mode_i = 1'b0; ack_en_i = 1'b0; last_rx_i = 1'b0;

    // R1 start timing
    pulse_req();
    chk("R1 sda low", sda_o, 0); chk("R1 scl high", scl_o, 1);
    chk("R9 start_bit after fall", start_bit_o, 0);
    count_scl(n);
    chk("R1 hold clocks", n, HOLD); chk("R1 done", start_done_o, 1);
    cyc(); chk("R1 done one cycle", start_done_o, 0); chk("R1 lines low", sda_o, 0);
    wait_release_i = 1'b1; cyc(); wait_release_i = 1'b0; cyc();
    chk("R1 handover", sda_o, 1);

    // R11 second request during hold
    pulse_req(); start_req_i = 1'b1; cyc(); start_req_i = 1'b0;
    count_scl(m);
    chk("R11 no timing restart", m + 1, HOLD);
    go_idle();

    // R2 repeated start
    phase_i = 2'd3; pulse_req(); phase_i = 2'd0;
    chk("R2 pending", start_bit_o, 1); chk("R2 sda high", sda_o, 1);
    cyc(3); chk("R2 still pending", start_bit_o, 1);
    wait_release_i = 1'b1; cyc(); wait_release_i = 1'b0;
    chk("R2 setup lines high", int'(sda_o && scl_o), 1);
    n = 0;
    while (sda_o && n < 50) begin cyc(); n++; end
    chk("R2 setup clocks", n, HOLD);
    chk("R9 cleared on fall", start_bit_o, 0);
    count_scl(m); chk("R2 hold clocks", m, HOLD);
    go_idle();

    // R3 reservation
    bus_busy_i = 1'b1; pulse_req();
    chk("R3 pending", start_bit_o, 1);
    cyc(4); chk("R3 no start while busy", sda_o, 1);
    pulse_req(); chk("R11 still pending", start_bit_o, 1);
    bus_busy_i = 1'b0; cyc();
    chk("R3 start after free", sda_o, 0); chk("R9 cleared", start_bit_o, 0);
    go_idle();

    // R4 reservation disabled
    resv_dis_i = 1'b1; bus_busy_i = 1'b1; pulse_req();
    chk("R4 fail set", resv_fail_o, 1); chk("R4 start_bit clear", start_bit_o, 0);
    bus_busy_i = 1'b0; cyc(2); chk("R4 no start", sda_o, 1);
    pulse_req(); chk("R4 fail cleared", resv_fail_o, 0); chk("R4 new start", sda_o, 0);
    go_idle(); resv_dis_i = 1'b0;

    // R5 cancellation sources
    bus_busy_i = 1'b1; pulse_req();
    arb_lost_i = 1'b1; cyc(); arb_lost_i = 1'b0;
    chk("R5 arb clears", start_bit_o, 0);
    bus_busy_i = 1'b0; cyc(); chk("R5 arb no start", sda_o, 1);
    bus_busy_i = 1'b1; pulse_req(); go_idle();
    chk("R5 release clears", start_bit_o, 0);
    pulse_req(); en_i = 1'b0; cyc(); en_i = 1'b1;
    chk("R5 disable clears", start_bit_o, 0);
    bus_busy_i = 1'b0; cyc(); chk("R5 disable no start", sda_o, 1);
    pulse_req(); cyc(); arb_lost_i = 1'b1; cyc(); arb_lost_i = 1'b0;
    chk("R5 arb aborts gen", int'(sda_o && scl_o), 1);

    // R10 disabled
    en_i = 1'b0; pulse_req();
    chk("R10 ignored", int'(sda_o && scl_o && !start_bit_o), 1);
    en_i = 1'b1; pulse_req(); chk("R10 baseline start", sda_o, 0);
    en_i = 1'b0; #1; chk("R10 lines released", int'(sda_o && scl_o), 1);
    cyc(); en_i = 1'b1; cyc(); chk("R10 state cleared", sda_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule